// File: doc/BRIEF.md
# SPI Flash Slave Serial Front-End

This block is the serial edge of a flash-style SPI target. It runs on a fast system clock and oversamples the four host pins: serial clock, active-low select, serial data in and active-low hold. Two-flop synchronizers bring the pins into the clock domain, and edges are found there. Both idle clock levels are accepted, low (mode 0) and high (mode 3). Data in is captured on rising serial-clock edges. Data out moves on falling edges. Incoming bits are packed most significant bit first into bytes. Each byte goes to a downstream command engine together with frame start and frame end strobes.

Received bytes leave on a valid-only stream. The serial host cannot be stalled, so there is no back-pressure: the engine must take every `rx_valid_o` pulse in the cycle it appears. Response bytes arrive on a valid/ready stream. The block offers one transfer slot per byte, on the first falling serial-clock edge of that byte. `tx_ready_o` is high for that single cycle, and a byte moves when `tx_valid_i` is high in the same cycle. The engine keeps `tx_valid_i` and `tx_data_i` steady until that cycle. If no byte is offered in a slot, the serial output stays in high impedance for the whole byte. Nothing is queued. The pad drives `so_o` only while `so_oe_o` is high.

The hold input pauses a transfer without losing the bit position. A rising select line aborts the frame and clears hold. The system clock must run at least eight times the serial-clock rate.

Top module: `spi_slave_front`

## Requirements
- R1: Eight serial-clock rising edges inside a frame form one byte. The first bit sampled becomes bit 7. `rx_valid_o` pulses for exactly one cycle with the byte on `rx_data_o`.
- R2: Frames work the same whether the serial clock idles low or high when select falls. Only rising edges capture data.
- R3: A falling edge on select (`cs_n_i` 1 to 0) pulses `frame_start_o` for one cycle and resets the bit position to the start of a byte.
- R4: A rising edge on select pulses `frame_end_o`. In that cycle `frame_aligned_o` is 1 if the frame ended on a byte boundary and 0 otherwise. A partial byte is discarded and produces no `rx_valid_o`.
- R5: Hold is entered only while the serial clock is low and `hold_n_i` is 0. If `hold_n_i` falls while the clock is high, entry waits until the clock next goes low.
- R6: Hold is left only while the serial clock is low and `hold_n_i` is 1. If `hold_n_i` rises while the clock is high, the exit waits until the clock next goes low.
- R7: While held, serial-clock and data-in transitions are ignored, `so_oe_o` is 0, and the bit position in both directions is kept.
- R8: A rising select during hold clears the hold and ends the frame. A later frame needs `hold_n_i` at 1 and a new select falling edge to carry data.
- R9: `so_oe_o` is 0 outside a frame, and for any byte whose transfer slot moved no response byte.
- R10: `tx_ready_o` is high only on the first falling serial-clock edge of a byte slot in an active, unheld frame. A byte taken there appears on `so_o`, bit 7 first, and shifts by one bit on each later falling edge of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| cs_n_i | input | 1 | Active-low select from host |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Active-low pause request |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for the serial data out pad |
| rx_valid_o | output | 1 | One-cycle strobe: received byte ready |
| rx_data_o | output | DATA_W | Received byte |
| frame_start_o | output | 1 | One-cycle strobe on select falling |
| frame_end_o | output | 1 | One-cycle strobe on select rising |
| frame_aligned_o | output | 1 | Frame ended on a byte boundary, valid with `frame_end_o` |
| tx_valid_i | input | 1 | Response byte offered |
| tx_data_i | input | DATA_W | Response byte |
| tx_ready_o | output | 1 | Transfer slot for a response byte |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2, and toggles the serial clock every six system cycles, a ratio of twelve. At that ratio the three-cycle edge-detect latency still lets a byte offered after `rx_valid_o` reach the next byte's transfer slot. It also leaves room to move `hold_n_i` while the serial clock is high and to watch the deferred entry and exit at the pins. The same settings make partial frames, a select rise during hold, and a frame opened with hold still asserted easy to reach in both idle clock levels.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_SI   = 2;
  localparam int unsigned PIN_HOLD = 3;
  localparam int unsigned NUM_PINS = 4;

  typedef struct packed {
    logic cs_rise;
    logic cs_fall;
    logic sck_rise;
    logic sck_fall;
    logic sck_lvl;
    logic hold_n_lvl;
    logic si_lvl;
  } sfe_evt_t;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
        else        chain <= {chain[STAGES-2:0], d[i]};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL[i];
        else        chain <= d[i];
      end
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/sfe_edge.sv
module sfe_edge
  import sfe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl,
  output sfe_evt_t            evt
);
  logic cs_q, sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= lvl[PIN_CS];
      sck_q <= lvl[PIN_SCK];
    end
  end

  always_comb begin
    evt.cs_rise    =  lvl[PIN_CS]  & ~cs_q;
    evt.cs_fall    = ~lvl[PIN_CS]  &  cs_q;
    evt.sck_rise   =  lvl[PIN_SCK] & ~sck_q;
    evt.sck_fall   = ~lvl[PIN_SCK] &  sck_q;
    evt.sck_lvl    =  lvl[PIN_SCK];
    evt.hold_n_lvl =  lvl[PIN_HOLD];
    evt.si_lvl     =  lvl[PIN_SI];
  end
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sfe_evt_t          evt,
  output logic              active_o,
  output logic              hold_o,
  output logic              slot_zero_o,
  output logic              fall_en_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              frame_aligned_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              active_q, hold_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh;
  logic              cs_evt, rise_en;

  assign cs_evt      = evt.cs_rise | evt.cs_fall;
  assign rise_en     = active_q & ~hold_q & evt.sck_rise & ~cs_evt;
  assign fall_en_o   = active_q & ~hold_q & evt.sck_fall & ~cs_evt;
  assign slot_zero_o = (cnt == '0);
  assign active_o    = active_q;
  assign hold_o      = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q        <= 1'b0;
      hold_q          <= 1'b0;
      cnt             <= '0;
      rx_sh           <= '0;
      rx_valid_o      <= 1'b0;
      rx_data_o       <= '0;
      frame_start_o   <= 1'b0;
      frame_end_o     <= 1'b0;
      frame_aligned_o <= 1'b0;
    end else begin
      rx_valid_o    <= 1'b0;
      frame_start_o <= 1'b0;
      frame_end_o   <= 1'b0;
      if (evt.cs_rise) begin
        if (active_q) begin
          frame_end_o     <= 1'b1;
          frame_aligned_o <= (cnt == '0);
        end
        active_q <= 1'b0;
        hold_q   <= 1'b0;
        cnt      <= '0;
      end else if (evt.cs_fall) begin
        active_q      <= 1'b1;
        frame_start_o <= 1'b1;
        hold_q        <= 1'b0;
        cnt           <= '0;
      end else if (active_q) begin
        if (hold_q) begin
          if (evt.hold_n_lvl && !evt.sck_lvl) hold_q <= 1'b0;
        end else if (!evt.hold_n_lvl && !evt.sck_lvl) begin
          hold_q <= 1'b1;
        end
        if (rise_en) begin
          rx_sh <= {rx_sh[DATA_W-2:0], evt.si_lvl};
          if (cnt == LAST) begin
            cnt        <= '0;
            rx_valid_o <= 1'b1;
            rx_data_o  <= {rx_sh[DATA_W-2:0], evt.si_lvl};
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R1: a byte strobe never lasts two cycles
  p_valid_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  // R4: a select rise never completes a partial byte
  p_no_partial_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.cs_rise |=> !rx_valid_o);
  // R5: hold only starts after a cycle with the serial clock low
  p_hold_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !$past(evt.sck_lvl));
  // R6: hold only ends inside a frame after a cycle with the serial clock low
  p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_q) && active_q) |-> !$past(evt.sck_lvl));
  // R7: bit position frozen while held
  p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !cs_evt) |=> (cnt == $past(cnt)) && !rx_valid_o);
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              hold_i,
  input  logic              fall_en_i,
  input  logic              slot_zero_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              so_o,
  output logic              so_oe_o
);
  logic [DATA_W-1:0] tx_sh;
  logic              drive_q;

  assign tx_ready_o = fall_en_i & slot_zero_i;
  assign so_o       = tx_sh[DATA_W-1];
  assign so_oe_o    = drive_q & active_i & ~hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      drive_q <= 1'b0;
    end else if (!active_i) begin
      drive_q <= 1'b0;
    end else if (fall_en_i) begin
      if (slot_zero_i) begin
        drive_q <= tx_valid_i;
        if (tx_valid_i) tx_sh <= tx_data_i;
      end else begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  // R10: an accepted byte shows its top bit on the next cycle
  p_load_drives_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready_o && tx_valid_i) |=> (so_o == $past(tx_data_i[DATA_W-1])));
  // R10: slots only occur inside an unheld frame
  p_ready_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> (active_i && !hold_i));
  // R9: leaving a frame silences the output from the next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !so_oe_o);
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
  import sfe_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              frame_start_o,
  output logic              frame_end_o,
  output logic              frame_aligned_o,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o
);
  localparam logic [NUM_PINS-1:0] PIN_IDLE = NUM_PINS'((1 << PIN_CS) | (1 << PIN_HOLD));

  logic [NUM_PINS-1:0] pins_raw, pins_sync;
  sfe_evt_t            evt;
  logic                active, hold, slot_zero, fall_en;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n_i;
    pins_raw[PIN_SCK]  = sck_i;
    pins_raw[PIN_SI]   = si_i;
    pins_raw[PIN_HOLD] = hold_n_i;
  end

  sfe_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_PINS), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_sync));

  sfe_edge u_edge (.clk(clk), .rst_n(rst_n), .lvl(pins_sync), .evt(evt));

  sfe_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .active_o(active), .hold_o(hold), .slot_zero_o(slot_zero), .fall_en_o(fall_en),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .frame_start_o(frame_start_o), .frame_end_o(frame_end_o),
    .frame_aligned_o(frame_aligned_o));

  sfe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active_i(active), .hold_i(hold),
    .fall_en_i(fall_en), .slot_zero_i(slot_zero),
    .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i), .tx_ready_o(tx_ready_o),
    .so_o(so_o), .so_oe_o(so_oe_o));
endmodule

// File: tb/spi_slave_front_test.sv
module spi_slave_front_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic so, so_oe, rx_valid, frame_start, frame_end, frame_aligned, tx_ready;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  spi_slave_front uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .hold_n_i(hold_n),
    .so_o(so), .so_oe_o(so_oe), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .frame_start_o(frame_start), .frame_end_o(frame_end), .frame_aligned_o(frame_aligned),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready));

  int checks = 0, errors = 0;
  bit mode3 = 1'b0;
  logic [7:0] got[$];
  int n_start = 0, n_end = 0, n_hs = 0;
  bit last_al = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: pin history queue plus integer state
  logic [3:0] mq[$];
  bit pv_cs, pv_sck, m_act, m_hold, m_drive, e_rv, e_fs, e_fe, e_al;
  int m_cnt;
  logic [7:0] m_rsh, m_tsh, e_rdata;

  task automatic model_reset();
    mq = '{4'b1001, 4'b1001};
    pv_cs = 1; pv_sck = 0; m_act = 0; m_hold = 0; m_drive = 0;
    e_rv = 0; e_fs = 0; e_fe = 0; e_al = 0; m_cnt = 0;
    m_rsh = 0; m_tsh = 0; e_rdata = 0;
  endtask

  task automatic model_step();
    logic [3:0] lv;
    bit csr, csf, sr, sf, quiet;
    lv = mq[0];
    csr = lv[0] && !pv_cs;  csf = !lv[0] && pv_cs;
    sr = lv[1] && !pv_sck;  sf = !lv[1] && pv_sck;
    quiet = m_act && !m_hold && !csr && !csf;
    e_rv = 0; e_fs = 0; e_fe = 0;
    if (!m_act) m_drive = 0;
    else if (quiet && sf) begin
      if (m_cnt == 0) begin
        m_drive = tx_valid;
        if (tx_valid) m_tsh = tx_data;
      end else m_tsh = m_tsh << 1;
    end
    if (csr) begin
      if (m_act) begin e_fe = 1; e_al = (m_cnt == 0); end
      m_act = 0; m_hold = 0; m_cnt = 0;
    end else if (csf) begin
      m_act = 1; e_fs = 1; m_hold = 0; m_cnt = 0;
    end else if (m_act) begin
      if (m_hold) begin
        if (lv[3] && !lv[1]) m_hold = 0;
      end else begin
        if (!lv[3] && !lv[1]) m_hold = 1;
        if (sr) begin
          m_rsh = {m_rsh[6:0], lv[2]};
          m_cnt++;
          if (m_cnt == 8) begin m_cnt = 0; e_rv = 1; e_rdata = m_rsh; end
        end
      end
    end
    pv_cs = lv[0]; pv_sck = lv[1];
    void'(mq.pop_front());
    mq.push_back({hold_n, si, sck, cs_n});
  endtask

  task automatic model_compare();
    logic [3:0] lv;
    bit sf, cse, e_tr, e_oe;
    lv = mq[0];
    sf = !lv[1] && pv_sck;
    cse = lv[0] != pv_cs;
    e_tr = m_act && !m_hold && sf && !cse && (m_cnt == 0);
    e_oe = m_drive && m_act && !m_hold;
    chk("R1", "rx_valid", rx_valid, e_rv);
    if (e_rv) chk("R1", "rx_data", rx_data, e_rdata);
    chk("R3", "frame_start", frame_start, e_fs);
    chk("R4", "frame_end", frame_end, e_fe);
    if (e_fe) chk("R4", "frame_aligned", frame_aligned, e_al);
    chk("R10", "tx_ready", tx_ready, e_tr);
    chk("R9", "so_oe", so_oe, e_oe);
    if (e_oe) chk("R10", "so", so, m_tsh[7]);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst_n) model_reset();
    else begin
      model_step();
      model_compare();
      if (rx_valid) got.push_back(rx_data);
      if (frame_start) n_start++;
      if (frame_end) begin n_end++; last_al = frame_aligned; end
      if (tx_ready && tx_valid) n_hs++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input bit b, output bit r);
    sck = 1'b0; si = b; tick(H);
    r = so; sck = 1'b1; tick(H);
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      bit t;
      xbit(d[i], t);
      r[i] = t;
    end
  endtask

  task automatic open_frame(bit m3);
    mode3 = m3; sck = m3; tick(4);
    cs_n = 1'b0; tick(H);
  endtask

  task automatic close_frame();
    if (!mode3) begin sck = 1'b0; tick(H); end
    cs_n = 1'b1; tick(2 * H);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
  end

  initial begin
    logic [7:0] r;
    bit b;
    tick(5); rst_n = 1'b1; tick(3);
    chk("R9", "reset so_oe", so_oe, 0);
    chk("R1", "reset rx_valid", rx_valid, 0);
    chk("R3", "reset frame_start", frame_start, 0);

    // R1 R2 R3 R4: mode 0, two whole bytes
    got.delete();
    open_frame(0); xbyte(8'hA5, r); xbyte(8'h3C, r); close_frame();
    chk("R1", "mode0 count", got.size(), 2);
    chk("R1", "mode0 byte0", got[0], 8'hA5);
    chk("R1", "mode0 byte1", got[1], 8'h3C);
    chk("R3", "frame starts", n_start, 1);
    chk("R4", "frame ends", n_end, 1);
    chk("R4", "aligned end", last_al, 1);

    // R2 R9 R10: mode 3 with one response byte
    got.delete();
    open_frame(1); xbyte(8'h05, r);
    tx_valid = 1'b1; tx_data = 8'h9B;
    xbyte(8'hFF, r);
    tx_valid = 1'b0;
    chk("R10", "response read", r, 8'h9B);
    chk("R10", "handshakes", n_hs, 1);
    xbit(1'b0, b);
    chk("R9", "no offer so_oe", so_oe, 0);
    for (int i = 0; i < 7; i++) xbit(1'b0, b);
    close_frame();
    chk("R2", "mode3 count", got.size(), 3);
    chk("R2", "mode3 byte0", got[0], 8'h05);
    chk("R2", "mode3 byte2", got[2], 8'h00);
    chk("R9", "idle so_oe", so_oe, 0);

    // R4: partial byte dropped
    got.delete();
    open_frame(0);
    for (int i = 0; i < 5; i++) xbit(1'b1, b);
    close_frame();
    chk("R4", "partial no byte", got.size(), 0);
    chk("R4", "partial ends", n_end, 3);
    chk("R4", "partial unaligned", last_al, 0);

    // R5 R6 R7: hold in the middle of a response byte
    got.delete();
    open_frame(0); xbyte(8'h0B, r);
    tx_valid = 1'b1; tx_data = 8'hC6;
    xbit(1'b0, b); r[7] = b;
    tx_valid = 1'b0;
    xbit(1'b1, b); r[6] = b;
    xbit(1'b0, b); r[5] = b;
    hold_n = 1'b0; tick(H);
    chk("R5", "deferred entry so_oe", so_oe, 1);
    sck = 1'b0; tick(H);
    chk("R5", "held so_oe", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; si = ~si; tick(H);
      sck = 1'b0; si = ~si; tick(H);
    end
    sck = 1'b1; tick(H);
    hold_n = 1'b1; tick(H);
    chk("R6", "deferred exit so_oe", so_oe, 0);
    sck = 1'b0; tick(H);
    chk("R7", "resumed so_oe", so_oe, 1);
    xbit(1'b1, b); r[4] = b;
    xbit(1'b1, b); r[3] = b;
    xbit(1'b0, b); r[2] = b;
    xbit(1'b1, b); r[1] = b;
    xbit(1'b0, b); r[0] = b;
    close_frame();
    chk("R7", "held response", r, 8'hC6);
    chk("R7", "held count", got.size(), 2);
    chk("R7", "held byte", got[1], 8'h5A);

    // R8: select rise during hold, reopen with hold asserted, then released
    got.delete();
    open_frame(0); xbit(1'b1, b); xbit(1'b1, b);
    hold_n = 1'b0; sck = 1'b0; tick(H);
    cs_n = 1'b1; tick(2 * H);
    chk("R8", "hold abort ends", n_end, 5);
    chk("R8", "hold abort unaligned", last_al, 0);
    open_frame(0); xbyte(8'h81, r); close_frame();
    chk("R8", "hold kept no byte", got.size(), 0);
    hold_n = 1'b1; tick(H);
    open_frame(0); xbyte(8'hE7, r); close_frame();
    chk("R8", "resume count", got.size(), 1);
    chk("R8", "resume byte", got[0], 8'hE7);
    chk("R8", "resume aligned", last_al, 1);

    tick(10);
    report();
  end
endmodule